// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This unit sits beside a 1024-deep FIFO. It holds two programmable thresholds, an empty-side offset and a full-side offset, and turns the FIFO's current occupancy into three active-low status flags: almost-empty, almost-full and half-full. The flags are registered, so each one reflects the occupancy presented on the previous clock edge.

The unit shares the write-enable and data pins with the FIFO. A select input steers each access. With the select HIGH, an active write enable becomes a strobe to the FIFO's write port. With the select LOW, the write enable programs an offset instead. Successive offset writes alternate between the empty-side and the full-side register, beginning with the empty side. Readback works the same way: with the select LOW and the read enable active, the next offset in the same alternating order is copied into a readback register.

Top module: `almost_flag_unit`

## Requirements
- R1: While reset is held and at the first edge after it, both offsets equal 127 (0x07F), the readback data is zero, almost_empty_n is 0, and almost_full_n and half_full_n are 1. Both alternation pointers restart at the empty-side register.
- R2: An offset write stores wr_data[9:0]. Bits 17:10 of rb_data always read as zero.
- R3: Offset writes (fifo_sel=0, wr_en_n=0 at a clock edge) go first to the empty-side register, then to the full-side register, and keep alternating.
- R4: fifo_wr is 1 exactly when fifo_sel=1 and wr_en_n=0. Such a cycle, and any cycle with wr_en_n=1, leaves both offsets unchanged.
- R5: With fifo_sel=0 and rd_en_n=0 at an edge, rb_data takes the next offset in empty-then-full alternation, using the values held before that edge. In any other cycle rb_data holds its value.
- R6: One edge after occupancy is sampled, almost_empty_n is 0 when that occupancy is at most the empty-side offset, and 1 otherwise.
- R7: One edge after occupancy is sampled, almost_full_n is 0 when that occupancy is at least 1024 minus the full-side offset, and 1 otherwise.
- R8: One edge after occupancy is sampled, half_full_n is 0 when that occupancy exceeds 512, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_sel | input | 1 | 1 steers accesses to the FIFO, 0 steers them to the offsets |
| wr_en_n | input | 1 | Active-low write enable, shared with the FIFO |
| rd_en_n | input | 1 | Active-low read enable, used here for offset readback |
| wr_data | input | 18 | Shared write data; the low 10 bits program an offset |
| occupancy | input | 11 | Current FIFO fill level, 0 to 1024 |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| rb_data | output | 18 | Offset readback register, zero-extended |
| almost_empty_n | output | 1 | Active-low almost-empty flag |
| almost_full_n | output | 1 | Active-low almost-full flag |
| half_full_n | output | 1 | Active-low half-full flag |

## Verification
The hardest situation to reach is a flag edge that sits exactly at a threshold the bench has just reprogrammed. The occupancy must land on the offset, one above it or one below it, in the cycles right after the pointer has moved the offset in question. Random stimulus alone seldom hits these points. The bench therefore draws occupancy mostly from values next to its own model's current offsets and next to the half-way mark, and mixes offset writes and readbacks into the same stream. Simultaneous write and readback cycles are also drawn; they show that readback returns the value held before the edge.

// File: rtl/afu_pkg.sv
package afu_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    typedef struct packed {
        logic ae_n;
        logic af_n;
        logic hf_n;
    } flags_t;

    localparam flags_t FLAGS_RST = '{ae_n: 1'b0, af_n: 1'b1, hf_n: 1'b1};

endpackage

// File: rtl/afu_decode.sv
module afu_decode (
    input  logic fifo_sel,
    input  logic wr_en_n,
    input  logic rd_en_n,
    output logic fifo_wr,
    output logic ofs_wr,
    output logic ofs_rd
);
    always_comb begin
        fifo_wr = fifo_sel & ~wr_en_n;
        ofs_wr  = ~fifo_sel & ~wr_en_n;
        ofs_rd  = ~fifo_sel & ~rd_en_n;
    end

    always_comb begin
        assert_decode_excl_R4: assert (!(fifo_wr && ofs_wr));
    end
endmodule

// File: rtl/afu_offset_bank.sv
module afu_offset_bank
    import afu_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int OFS_W   = 10,
    parameter int DEF_OFS = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ofs_wr,
    input  logic              ofs_rd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rb_data
);
    localparam logic [OFS_W-1:0] OFS_RST = OFS_W'(DEF_OFS);

    typedef struct packed {
        logic [OFS_W-1:0]  empty;
        logic [OFS_W-1:0]  full;
        slot_e             wr_slot;
        slot_e             rd_slot;
        logic [DATA_W-1:0] rb;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (ofs_wr) begin
            if (bank_q.wr_slot == SLOT_EMPTY) begin
                bank_d.empty = wr_data[OFS_W-1:0];
            end else begin
                bank_d.full = wr_data[OFS_W-1:0];
            end
            bank_d.wr_slot = (bank_q.wr_slot == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
        end
        if (ofs_rd) begin
            bank_d.rb = (bank_q.rd_slot == SLOT_EMPTY) ? DATA_W'(bank_q.empty)
                                                     : DATA_W'(bank_q.full);
            bank_d.rd_slot = (bank_q.rd_slot == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.empty   <= OFS_RST;
            bank_q.full    <= OFS_RST;
            bank_q.wr_slot <= SLOT_EMPTY;
            bank_q.rd_slot <= SLOT_EMPTY;
            bank_q.rb      <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign empty_ofs = bank_q.empty;
    assign full_ofs  = bank_q.full;
    assign rb_data   = bank_q.rb;

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_wr |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_empty_slot_keeps_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_wr && bank_q.wr_slot == SLOT_EMPTY) |=> $stable(full_ofs));

    assert_rb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_rd |=> $stable(rb_data));

    generate
        if (DATA_W > OFS_W) begin : g_upper_zero
            assert_rb_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
                rb_data[DATA_W-1:OFS_W] == '0);
        end
    endgenerate
endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen
    import afu_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int OFS_W = 10,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occupancy,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output flags_t           flags
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] OFS_MAX = CNT_W'((1 << OFS_W) - 1);

    flags_t           flags_d, flags_q;
    logic [CNT_W-1:0] af_thr;
    logic             past_valid_q;

    always_comb begin
        af_thr       = DEPTH_C - CNT_W'(full_ofs);
        flags_d      = flags_q;
        flags_d.ae_n = !(occupancy <= CNT_W'(empty_ofs));
        flags_d.af_n = !(occupancy >= af_thr);
        flags_d.hf_n = !(occupancy > HALF_C);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q      <= FLAGS_RST;
            past_valid_q <= 1'b0;
        end else begin
            flags_q      <= flags_d;
            past_valid_q <= 1'b1;
        end
    end

    assign flags = flags_q;

    assert_ae_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && occupancy == '0) |=> !flags.ae_n);

    assert_ae_above_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && occupancy > OFS_MAX) |=> flags.ae_n);

    assert_af_at_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && occupancy == DEPTH_C) |=> !flags.af_n);

    assert_hf_low_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && occupancy <= HALF_C) |=> flags.hf_n);

    assert_hf_at_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && occupancy == DEPTH_C) |=> !flags.hf_n);
endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit
    import afu_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int DATA_W  = 18,
    parameter int DEF_OFS = 127
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_sel,
    input  logic                       wr_en_n,
    input  logic                       rd_en_n,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH):0]     occupancy,
    output logic                       fifo_wr,
    output logic [DATA_W-1:0]          rb_data,
    output logic                       almost_empty_n,
    output logic                       almost_full_n,
    output logic                       half_full_n
);
    localparam int OFS_W = $clog2(DEPTH);
    localparam int CNT_W = OFS_W + 1;

    logic             ofs_wr, ofs_rd;
    logic [OFS_W-1:0] empty_ofs, full_ofs;
    flags_t           flags;

    afu_decode u_decode (
        .fifo_sel (fifo_sel),
        .wr_en_n  (wr_en_n),
        .rd_en_n  (rd_en_n),
        .fifo_wr  (fifo_wr),
        .ofs_wr   (ofs_wr),
        .ofs_rd   (ofs_rd)
    );

    afu_offset_bank #(
        .DATA_W  (DATA_W),
        .OFS_W   (OFS_W),
        .DEF_OFS (DEF_OFS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ofs_wr    (ofs_wr),
        .ofs_rd    (ofs_rd),
        .wr_data   (wr_data),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rb_data   (rb_data)
    );

    afu_flag_gen #(
        .DEPTH (DEPTH),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .occupancy (occupancy),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .flags     (flags)
    );

    assign almost_empty_n = flags.ae_n;
    assign almost_full_n  = flags.af_n;
    assign half_full_n    = flags.hf_n;

    assert_fifo_path_keeps_offsets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: tb/almost_flag_unit_tb_top.sv
`timescale 1ns/1ps
module almost_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_sel = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        rd_en_n = 1'b1;
    logic [17:0] wr_data = '0;
    logic [10:0] occupancy = '0;
    logic        fifo_wr;
    logic [17:0] rb_data;
    logic        almost_empty_n, almost_full_n, half_full_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [9:0]  m_e = 10'd127;
    logic [9:0]  m_f = 10'd127;
    bit          m_wp = 0;
    bit          m_rp = 0;
    logic [17:0] m_rb = '0;

    always #2.5 clk = ~clk;

    almost_flag_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fifo_sel       (fifo_sel),
        .wr_en_n        (wr_en_n),
        .rd_en_n        (rd_en_n),
        .wr_data        (wr_data),
        .occupancy      (occupancy),
        .fifo_wr        (fifo_wr),
        .rb_data        (rb_data),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n),
        .half_full_n    (half_full_n)
    );

    function automatic bit exp_ae(int o, int e); return !(o <= e); endfunction
    function automatic bit exp_af(int o, int f); return !(o >= 1024 - f); endfunction
    function automatic bit exp_hf(int o); return !(o > 512); endfunction

    task automatic chk(input bit ok, input string req, input string tag,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic step(input bit sel, input bit wen, input bit ren,
                        input logic [17:0] d, input int occ, input string tag);
        bit e_ae, e_af, e_hf;
        logic [9:0] old_e, old_f;
        @(negedge clk);
        fifo_sel = sel; wr_en_n = wen; rd_en_n = ren; wr_data = d;
        occupancy = 11'(occ);
        #1;
        chk(fifo_wr == (sel && !wen), "R4", tag, fifo_wr, sel && !wen);
        e_ae = exp_ae(occ, m_e); e_af = exp_af(occ, m_f); e_hf = exp_hf(occ);
        old_e = m_e; old_f = m_f;
        if (!sel && !wen) begin
            if (!m_wp) m_e = d[9:0]; else m_f = d[9:0];
            m_wp = !m_wp;
        end
        if (!sel && !ren) begin
            m_rb = m_rp ? {8'd0, old_f} : {8'd0, old_e};
            m_rp = !m_rp;
        end
        @(posedge clk);
        #1;
        chk(rb_data == m_rb, "R5", tag, rb_data, m_rb);
        chk(almost_empty_n == e_ae, "R6", tag, almost_empty_n, e_ae);
        chk(almost_full_n == e_af, "R7", tag, almost_full_n, e_af);
        chk(half_full_n == e_hf, "R8", tag, half_full_n, e_hf);
    endtask

    function automatic int pick_occ();
        int r = $urandom_range(0, 9);
        int o;
        case (r)
            0, 1: o = int'(m_e) + $urandom_range(0, 2) - 1;
            2, 3: o = 1024 - int'(m_f) + $urandom_range(0, 2) - 1;
            4:    o = 511 + $urandom_range(0, 2);
            5:    o = ($urandom_range(0, 1) == 0) ? 0 : 1024;
            default: o = $urandom_range(0, 1024);
        endcase
        if (o < 0) o = 0;
        if (o > 1024) o = 1024;
        return o;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        occupancy = 11'd700;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk(rb_data == 0, "R1", "reset rb", rb_data, 0);
        chk(almost_empty_n == 0, "R1", "reset ae", almost_empty_n, 0);
        chk(almost_full_n == 1, "R1", "reset af", almost_full_n, 1);
        chk(half_full_n == 1, "R1", "reset hf", half_full_n, 1);
        occupancy = 11'd0;
        rst_n = 1'b1;
        // R1: defaults read back, empty side first
        step(0, 1, 0, 18'h0, 0, "R1 readback default empty");
        step(0, 1, 0, 18'h0, 0, "R1 readback default full");
        // R2/R3: writes land empty first, upper bits dropped
        step(0, 0, 1, 18'h3FF05, 10, "R2 R3 write empty");
        step(0, 0, 1, 18'h2C040, 10, "R2 R3 write full");
        step(0, 1, 0, 18'h0, 10, "R2 readback empty");
        chk(rb_data == 18'h305, "R2", "empty low bits", rb_data, 18'h305);
        step(0, 1, 0, 18'h0, 10, "R2 readback full");
        chk(rb_data == 18'h040, "R3", "full second", rb_data, 18'h040);
        // R4: fifo writes and idle enables leave offsets alone
        step(1, 0, 1, 18'h00011, 20, "R4 fifo write");
        step(0, 1, 1, 18'h00022, 20, "R4 idle");
        step(1, 1, 0, 18'h00033, 20, "R5 fifo-side read ignored");
        step(0, 1, 0, 18'h0, 20, "R4 readback empty");
        step(0, 1, 0, 18'h0, 20, "R4 readback full");
        // R6..R8: thresholds at the programmed offsets
        step(1, 1, 1, 0, int'(m_e), "R6 at empty offset");
        step(1, 1, 1, 0, int'(m_e) + 1, "R6 above empty offset");
        step(1, 1, 1, 0, 1024 - int'(m_f), "R7 at full threshold");
        step(1, 1, 1, 0, 1023 - int'(m_f), "R7 below full threshold");
        step(1, 1, 1, 0, 512, "R8 at half");
        step(1, 1, 1, 0, 513, "R8 above half");
        step(1, 1, 1, 0, 1024, "R7 R8 full");
        // R5: write and readback in the same edge
        step(0, 0, 0, 18'h00123, 300, "R5 simultaneous");
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 7);
            bit sel = (r < 3) ? 1'b0 : 1'b1;
            bit wen = ($urandom_range(0, 2) != 0);
            bit ren = ($urandom_range(0, 2) != 0);
            logic [17:0] d = 18'($urandom);
            step(sel, wen, ren, d, pick_occ(), "random R3 R4 R5 R6 R7 R8");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule